// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a set of SDRAM arrays refreshed. A slow free-running timebase (nominally 32 kHz) is brought into the memory clock domain through a synchronizer. Each rising edge of the timebase raises one refresh request. The scheduler asks the access engine for the command bus and waits until the engine grants it. A grant means that any burst in flight has finished. The scheduler then holds the engine off and drives its own command sequence: one precharge-all, then a short burst of auto-refresh commands. When the sequence ends it releases the bus.

Each chip-select array has its own 2-bit rate field, so arrays of different density can share one controller. An array whose rate is zero is never selected. If every rate is zero, a timebase edge causes no activity. The row-precharge wait and the row-cycle wait are counts of memory-clock cycles, supplied on ports. Only the SDRAM command pins and a drive-enable are produced. Pins shared with other devices are not touched, so other traffic can proceed during a refresh. The access engine muxes these command pins onto the SDRAM bus while `cmd_drive` is high.

Top module: `refresh_scheduler`

## Requirements
- R1: During and after reset, `ref_req`, `ref_hold`, `cmd_drive` and `sd_a10` are low, and `sd_ras_n`, `sd_cas_n`, `sd_we_n` and every `sd_cs_n` bit are high, until a sequence starts.
- R2: A rising edge of `slow_tick` is resynchronized by two flops. When the scheduler is idle, `ref_req` goes high at the third rising clock edge at which `slow_tick` is sampled high.
- R3: Array i takes its rate from `rate_cfg[2i+1:2i]`. The encodings 00, 01, 10 and 11 request 0, 1, 2 and 4 auto-refresh commands per timebase interval. The rates are captured at the clock edge where `ref_req` rises.
- R4: If every rate field is 00 when a timebase edge is taken, no request is raised and no command is driven.
- R5: `ref_req` stays high until `ref_grant` is sampled high. At that edge `ref_req` falls, `ref_hold` and `cmd_drive` rise, and a precharge-all is driven: `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=0, `sd_a10`=1, with `sd_cs_n` low only for arrays whose rate is nonzero.
- R6: The first auto-refresh command appears max(`trp_cyc`,1) cycles after the precharge-all: `sd_ras_n`=0, `sd_cas_n`=0, `sd_we_n`=1, `sd_a10`=0. Refresh number k (counting from 0) selects only the arrays whose count exceeds k.
- R7: Further auto-refresh commands follow every max(`trc_cyc`,1) cycles, until the largest count among the captured arrays has been issued. In every other cycle of the sequence, all command pins are high and `sd_a10` is low.
- R8: `ref_hold` and `cmd_drive` fall max(`trc_cyc`,1) cycles after the last auto-refresh. A new `ref_req` can rise no earlier than two cycles after that.
- R9: Timebase edges that arrive while a sequence is pending or running are merged into one request. That request is served after the current sequence completes.
- R10: `ref_grant` has no effect while `ref_req` is low. `ref_hold` never rises in a cycle that did not follow a cycle with `ref_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Asynchronous slow refresh timebase |
| rate_cfg | input | 2*NUM_CS | Per-array refresh rate fields |
| trp_cyc | input | TW | Row-precharge wait in cycles (0 treated as 1) |
| trc_cyc | input | TW | Row-cycle wait in cycles (0 treated as 1) |
| ref_grant | input | 1 | Access engine idle and yielding the bus |
| ref_req | output | 1 | Refresh wants the command bus |
| ref_hold | output | 1 | Access engine must stay off the SDRAM |
| cmd_drive | output | 1 | Refresh command pins are valid for the bus |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cs_n | output | NUM_CS | Per-array chip selects, active low |
| sd_a10 | output | 1 | Address bit 10, high selects all banks on precharge |

## Verification
Every output is registered, so each result lands on a fixed edge:
- `ref_req` three edges after the timebase is first sampled high.
- The precharge-all on the edge that samples the grant.
- Each refresh exactly max(tRP,1) or max(tRC,1) edges after the command before it.
- The release max(tRC,1) edges after the last refresh.

The bench holds a behavioural model that advances on the same rising edge, using only the inputs. The model's output vector is compared with the design's at the following falling edge. Per-scenario totals of precharges, refreshes per chip select and sequences check counts, merging and suppression. A directed measurement confirms the three-edge request latency.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  localparam int RATE_W = 2;
  localparam int RCNT_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_BUS,
    ST_PRECHARGE,
    ST_WAIT_TRP,
    ST_REFRESH,
    ST_WAIT_TRC,
    ST_DONE
  } seq_state_t;

  function automatic logic [RCNT_W-1:0] rate_to_count(input logic [RATE_W-1:0] r);
    logic [RCNT_W-1:0] c;
    case (r)
      2'b00:   c = 3'd0;
      2'b01:   c = 3'd1;
      2'b10:   c = 3'd2;
      default: c = 3'd4;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/refsched_tick_sync.sv
module refsched_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic tick_rise
);

  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[SYNC_STAGES-1:0], tick_async};
  end

  assign tick_rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

  // R2: a detected edge lasts a single cycle
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
    tick_rise |=> !tick_rise);

endmodule

// File: rtl/refsched_rate_decode.sv
module refsched_rate_decode
  import refsched_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic [NUM_CS*RATE_W-1:0] rate_cfg,
  output logic [NUM_CS*RCNT_W-1:0] cnt_flat,
  output logic [NUM_CS-1:0]        en_mask,
  output logic [RCNT_W-1:0]        max_cnt
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cnt_flat[g*RCNT_W +: RCNT_W] = rate_to_count(rate_cfg[g*RATE_W +: RATE_W]);
    assign en_mask[g] = |rate_cfg[g*RATE_W +: RATE_W];
  end

  always_comb begin
    max_cnt = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cnt_flat[i*RCNT_W +: RCNT_W] > max_cnt) max_cnt = cnt_flat[i*RCNT_W +: RCNT_W];
    end
  end

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
  import refsched_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int TW     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_rise,
  input  logic [NUM_CS*RCNT_W-1:0] cnt_flat,
  input  logic [NUM_CS-1:0]        en_mask,
  input  logic [RCNT_W-1:0]        max_cnt,
  input  logic [TW-1:0]            trp_cyc,
  input  logic [TW-1:0]            trc_cyc,
  input  logic                     ref_grant,
  output logic                     ref_req,
  output logic                     ref_hold,
  output logic                     cmd_drive,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [NUM_CS-1:0]        sd_cs_n,
  output logic                     sd_a10
);

  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

  seq_state_t                state;
  logic                      pend;
  logic [TW-1:0]             wcnt;
  logic [RCNT_W-1:0]         ref_idx;
  logic [NUM_CS*RCNT_W-1:0]  snap_cnt;
  logic [NUM_CS-1:0]         snap_en;
  logic [RCNT_W-1:0]         snap_max;
  logic [TW-1:0]             trp_eff;
  logic [TW-1:0]             trc_eff;
  logic [NUM_CS-1:0]         ref_cs_n;
  logic                      wait_over;

  assign trp_eff   = (trp_cyc == '0) ? ONE : trp_cyc;
  assign trc_eff   = (trc_cyc == '0) ? ONE : trc_cyc;
  assign wait_over = (wcnt == ONE);

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) begin
      ref_cs_n[i] = !(snap_cnt[i*RCNT_W +: RCNT_W] > ref_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      wcnt      <= '0;
      ref_idx   <= '0;
      snap_cnt  <= '0;
      snap_en   <= '0;
      snap_max  <= '0;
      ref_req   <= 1'b0;
      ref_hold  <= 1'b0;
      cmd_drive <= 1'b0;
      sd_ras_n  <= 1'b1;
      sd_cas_n  <= 1'b1;
      sd_we_n   <= 1'b1;
      sd_cs_n   <= '1;
      sd_a10    <= 1'b0;
    end else begin
      pend     <= pend | tick_rise;
      sd_ras_n <= 1'b1;
      sd_cas_n <= 1'b1;
      sd_we_n  <= 1'b1;
      sd_cs_n  <= '1;
      sd_a10   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pend || tick_rise) begin
            pend <= 1'b0;
            if (|en_mask) begin
              state    <= ST_WAIT_BUS;
              ref_req  <= 1'b1;
              snap_cnt <= cnt_flat;
              snap_en  <= en_mask;
              snap_max <= max_cnt;
            end
          end
        end
        ST_WAIT_BUS: begin
          if (ref_grant) begin
            state     <= ST_PRECHARGE;
            ref_req   <= 1'b0;
            ref_hold  <= 1'b1;
            cmd_drive <= 1'b1;
            sd_ras_n  <= 1'b0;
            sd_we_n   <= 1'b0;
            sd_a10    <= 1'b1;
            sd_cs_n   <= ~snap_en;
            wcnt      <= trp_eff;
            ref_idx   <= '0;
          end
        end
        ST_PRECHARGE, ST_WAIT_TRP: begin
          if (wait_over) begin
            state    <= ST_REFRESH;
            sd_ras_n <= 1'b0;
            sd_cas_n <= 1'b0;
            sd_cs_n  <= ref_cs_n;
            ref_idx  <= ref_idx + 1'b1;
            wcnt     <= trc_eff;
          end else begin
            state <= ST_WAIT_TRP;
            wcnt  <= wcnt - ONE;
          end
        end
        ST_REFRESH, ST_WAIT_TRC: begin
          if (wait_over) begin
            if (ref_idx == snap_max) begin
              state     <= ST_DONE;
              ref_hold  <= 1'b0;
              cmd_drive <= 1'b0;
            end else begin
              state    <= ST_REFRESH;
              sd_ras_n <= 1'b0;
              sd_cas_n <= 1'b0;
              sd_cs_n  <= ref_cs_n;
              ref_idx  <= ref_idx + 1'b1;
              wcnt     <= trc_eff;
            end
          end else begin
            state <= ST_WAIT_TRC;
            wcnt  <= wcnt - ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: request and hold are never both high
  assert_req_hold_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(ref_req && ref_hold));

  // R5: request stays until grant is seen
  assert_req_until_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_grant) |=> ref_req);

  // R5: the first command of a sequence is precharge-all
  assert_first_cmd_pre_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_hold) |-> (!sd_ras_n && sd_cas_n && !sd_we_n && sd_a10));

  // R6: auto-refresh never drives A10
  assert_ref_a10_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!sd_ras_n && !sd_cas_n) |-> (!sd_a10 && sd_we_n && cmd_drive));

  // R1: the command pins idle whenever not driving
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !cmd_drive |-> (sd_ras_n && sd_cas_n && sd_we_n && (&sd_cs_n) && !sd_a10));

  // R10: hold cannot rise without a pending request
  assert_grant_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!ref_req && !ref_hold) |=> !ref_hold);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int NUM_CS      = 2,
  parameter int TW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slow_tick,
  input  logic [2*NUM_CS-1:0]      rate_cfg,
  input  logic [TW-1:0]            trp_cyc,
  input  logic [TW-1:0]            trc_cyc,
  input  logic                     ref_grant,
  output logic                     ref_req,
  output logic                     ref_hold,
  output logic                     cmd_drive,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [NUM_CS-1:0]        sd_cs_n,
  output logic                     sd_a10
);

  logic                     tick_rise;
  logic [NUM_CS*RCNT_W-1:0] cnt_flat;
  logic [NUM_CS-1:0]        en_mask;
  logic [RCNT_W-1:0]        max_cnt;

  refsched_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .tick_async (slow_tick),
    .tick_rise  (tick_rise)
  );

  refsched_rate_decode #(.NUM_CS(NUM_CS)) u_dec (
    .rate_cfg (rate_cfg),
    .cnt_flat (cnt_flat),
    .en_mask  (en_mask),
    .max_cnt  (max_cnt)
  );

  refsched_seq #(.NUM_CS(NUM_CS), .TW(TW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick_rise (tick_rise),
    .cnt_flat  (cnt_flat),
    .en_mask   (en_mask),
    .max_cnt   (max_cnt),
    .trp_cyc   (trp_cyc),
    .trc_cyc   (trc_cyc),
    .ref_grant (ref_grant),
    .ref_req   (ref_req),
    .ref_hold  (ref_hold),
    .cmd_drive (cmd_drive),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_cs_n   (sd_cs_n),
    .sd_a10    (sd_a10)
  );

endmodule

// File: tb/test_refresh_scheduler.sv
`timescale 1ns/1ps
module test_refresh_scheduler;

  localparam int NUM_CS = 2;
  localparam int TW     = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              slow_tick = 1'b0;
  logic [2*NUM_CS-1:0] rate_cfg = '0;
  logic [TW-1:0]     trp_cyc = 8'd2;
  logic [TW-1:0]     trc_cyc = 8'd3;
  logic              ref_grant = 1'b0;
  logic              ref_req, ref_hold, cmd_drive, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [NUM_CS-1:0] sd_cs_n;

  always #2.5 clk = ~clk;

  refresh_scheduler #(.NUM_CS(NUM_CS), .TW(TW)) i_refresh_scheduler (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .rate_cfg(rate_cfg),
    .trp_cyc(trp_cyc), .trc_cyc(trc_cyc), .ref_grant(ref_grant),
    .ref_req(ref_req), .ref_hold(ref_hold), .cmd_drive(cmd_drive),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cs_n(sd_cs_n), .sd_a10(sd_a10)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  cnt_of [4] = '{0, 1, 2, 4};
  int  m_mode, m_timer, m_idx, m_total;
  int  m_cnt [NUM_CS];
  bit  m_pend, q1, q2, q3;
  bit  e_req, e_hold, e_drive, e_ras, e_cas, e_we, e_a10;
  bit [NUM_CS-1:0] e_cs;

  always @(posedge clk) begin
    bit rise, any;
    if (rst) begin
      m_mode = 0; m_pend = 0; q1 = 0; q2 = 0; q3 = 0;
      e_req = 0; e_hold = 0; e_drive = 0;
      e_ras = 1; e_cas = 1; e_we = 1; e_a10 = 0; e_cs = '1;
    end else begin
      rise = q2 && !q3;
      q3 = q2; q2 = q1; q1 = slow_tick;
      e_ras = 1; e_cas = 1; e_we = 1; e_a10 = 0; e_cs = '1;
      if (m_mode == 0) begin
        if (m_pend || rise) begin
          m_pend = 0; any = 0; m_total = 0;
          for (int i = 0; i < NUM_CS; i++) begin
            m_cnt[i] = cnt_of[rate_cfg[2*i +: 2]];
            if (m_cnt[i] > 0) any = 1;
            if (m_cnt[i] > m_total) m_total = m_cnt[i];
          end
          if (any) begin m_mode = 1; e_req = 1; end
        end
      end else begin
        m_pend = m_pend | rise;
        if (m_mode == 1) begin
          if (ref_grant) begin
            m_mode = 2; e_req = 0; e_hold = 1; e_drive = 1;
            e_ras = 0; e_we = 0; e_a10 = 1;
            for (int i = 0; i < NUM_CS; i++) e_cs[i] = !(m_cnt[i] > 0);
            m_timer = (trp_cyc == 0) ? 1 : int'(trp_cyc);
            m_idx = 0;
          end
        end else if (m_mode == 2) begin
          m_timer--;
          if (m_timer == 0) begin
            if (m_idx == m_total) begin
              m_mode = 3; e_hold = 0; e_drive = 0;
            end else begin
              e_ras = 0; e_cas = 0;
              for (int i = 0; i < NUM_CS; i++) e_cs[i] = !(m_cnt[i] > m_idx);
              m_idx++;
              m_timer = (trc_cyc == 0) ? 1 : int'(trc_cyc);
            end
          end
        end else begin
          m_mode = 0;
        end
      end
    end
  end

  // ---------------- per-cycle comparison and tallies ----------------
  bit compare_on = 0;
  int n_pre [NUM_CS];
  int n_ref [NUM_CS];
  int n_seq = 0;
  bit hold_d = 0;

  always @(negedge clk) begin
    if (compare_on) begin
      if (ref_req !== e_req)
        chk(0, "R2", "ref_req", int'(ref_req), int'(e_req));
      else if (ref_hold !== e_hold || cmd_drive !== e_drive)
        chk(0, "R8", "hold/drive", int'({ref_hold, cmd_drive}), int'({e_hold, e_drive}));
      else
        chk({sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_cs_n} === {e_ras, e_cas, e_we, e_a10, e_cs},
            "R6", "command pins", int'({sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_cs_n}),
            int'({e_ras, e_cas, e_we, e_a10, e_cs}));
    end
    if (!rst) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (cmd_drive && !sd_ras_n && sd_cas_n && !sd_we_n && !sd_cs_n[i]) n_pre[i]++;
        if (cmd_drive && !sd_ras_n && !sd_cas_n && !sd_cs_n[i]) n_ref[i]++;
      end
      if (ref_hold && !hold_d) n_seq++;
      hold_d = ref_hold;
    end
  end

  // ---------------- grant driver ----------------
  int grant_delay = 0;
  bit grant_force = 0;
  int gcnt = 0;
  always @(negedge clk) begin
    if (grant_force) ref_grant = 1;
    else if (ref_req) begin
      if (gcnt >= grant_delay) ref_grant = 1;
      else begin ref_grant = 0; gcnt++; end
    end else begin
      ref_grant = 0; gcnt = 0;
    end
  end

  task automatic clear_tally();
    for (int i = 0; i < NUM_CS; i++) begin n_pre[i] = 0; n_ref[i] = 0; end
    n_seq = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) slow_tick = 1;
    repeat (4) @(negedge clk);
    slow_tick = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(!ref_req && !ref_hold && !cmd_drive && !sd_a10, "R1", "reset ctrl", int'({ref_req, ref_hold, cmd_drive, sd_a10}), 0);
    chk(sd_ras_n && sd_cas_n && sd_we_n && (&sd_cs_n), "R1", "reset pins", int'({sd_ras_n, sd_cas_n, sd_we_n, sd_cs_n}), 31);
    compare_on = 1;

    // R4: all rates zero, edge is dropped
    clear_tally();
    rate_cfg = 4'b0000;
    pulse_tick();
    wait_quiet(20);
    chk(n_seq == 0, "R4", "sequences with zero rate", n_seq, 0);
    chk(n_pre[0] + n_pre[1] + n_ref[0] + n_ref[1] == 0, "R4", "commands with zero rate", n_pre[0] + n_ref[0], 0);

    // R2 latency, R3 single refresh, R5 delayed grant, R6 tRP
    clear_tally();
    rate_cfg = 4'b0001; trp_cyc = 2; trc_cyc = 3; grant_delay = 4;
    @(negedge clk) slow_tick = 1;
    lat = 0;
    while (!ref_req && lat < 10) begin @(negedge clk); lat++; end
    chk(lat == 3, "R2", "request latency", lat, 3);
    repeat (4) @(negedge clk);
    slow_tick = 0;
    wait_quiet(40);
    chk(n_pre[0] == 1 && n_pre[1] == 0, "R5", "precharge cs mask", n_pre[0] * 10 + n_pre[1], 10);
    chk(n_ref[0] == 1 && n_ref[1] == 0, "R3", "rate 01 refreshes", n_ref[0] * 10 + n_ref[1], 10);
    chk(n_seq == 1, "R8", "one sequence", n_seq, 1);

    // R3/R7: counts 2 and 4, zero waits clamp to one
    clear_tally();
    rate_cfg = 4'b1110; trp_cyc = 0; trc_cyc = 0; grant_delay = 0;
    pulse_tick();
    wait_quiet(30);
    chk(n_ref[0] == 2, "R3", "rate 10 refreshes", n_ref[0], 2);
    chk(n_ref[1] == 4, "R7", "rate 11 refreshes", n_ref[1], 4);

    // R9: extra edges during a sequence collapse to one
    clear_tally();
    rate_cfg = 4'b0101; trp_cyc = 3; trc_cyc = 6; grant_delay = 10;
    pulse_tick();
    pulse_tick();
    pulse_tick();
    wait_quiet(80);
    chk(n_seq == 2, "R9", "merged sequences", n_seq, 2);
    chk(n_ref[0] == 2 && n_ref[1] == 2, "R9", "refreshes after merge", n_ref[0] + n_ref[1], 4);

    // R10: grant without request is ignored
    clear_tally();
    grant_force = 1;
    wait_quiet(20);
    chk(n_seq == 0 && !ref_hold, "R10", "hold without request", n_seq, 0);
    rate_cfg = 4'b1100; trc_cyc = 2; trp_cyc = 1;
    pulse_tick();
    wait_quiet(30);
    grant_force = 0;
    chk(n_ref[0] == 0 && n_ref[1] == 4, "R10", "sequence under standing grant", n_ref[0] * 10 + n_ref[1], 4);
    chk(n_pre[1] == 1 && n_pre[0] == 0, "R5", "precharge only enabled cs", n_pre[0] * 10 + n_pre[1], 1);

    wait_quiet(5);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule